// File: doc/BRIEF.md
# Multiply-Accumulate Step Sequencer with Circular-Buffer Operand Fetch

This block carries out one step of a multiply-accumulate loop in a fixed sequence of cycles. When `start` is pulsed, the block captures the following values from the surrounding register file:

- two 16-bit operands;
- three 20-bit pointers;
- two 16-bit buffer masks;
- an 8-bit offset field.

The block first forms the fractional product of the two operands, which is the signed product doubled. It hands that product to an external accumulator over a request/acknowledge pair. A flag marks the one product that cannot be represented.

After the accumulator accepts the product, the block steps each of two pointers by a signed 4-bit offset. Each step wraps inside a power-of-two buffer described by that pointer's mask. The block then reads the next two operands from memory through a byte/word read port. A word read at an odd address is split into two byte reads.

The updated operands and pointers stay on the outputs once `busy` falls. The enclosing datapath writes them back to its registers. While the first operand is being fetched, its previous value is copied into the low half of the third pointer.

Top module: `mac_fetch_seq`

## Requirements
- R1: After reset, `busy`, `acc_req` and `mem_rd` are low and every operand and pointer output is zero.
- R2: `acc_data` carries the signed product of the captured operands times two, truncated to 32 bits, while `acc_req` is high.
- R3: `acc_pov` is 1 exactly when the product is 0x80000000, which happens only when both operands are 0x8000; otherwise it is 0.
- R4: `acc_req` stays high with `acc_data` unchanged until `acc_ack`. No memory read is issued and neither pointer moves before the acknowledge.
- R5: The first pointer becomes (p AND NOT m) OR ((p + sext(offs[7:4])) AND m). Here m is `mask_x` zero-extended to 20 bits, and a mask of zero counts as 0xFFFF.
- R6: The second pointer is updated by the same rule, using `offs[3:0]` and `mask_y`.
- R7: Bits 15:0 of the third pointer take the old first operand, and bits 19:16 keep their captured value.
- R8: A read at an even address is one word read (`mem_word`=1). A read at an odd address is two byte reads (`mem_word`=0): the first at the address, the second at the address plus one, on consecutive cycles. The first read uses the new first pointer and the next read uses the new second pointer.
- R9: Each operand is loaded from the read at its new pointer. Word data is `mem_rdata[15:0]`, and byte data is `mem_rdata[7:0]` one cycle after the strobe. Byte pairs are assembled high byte first.
- R10: A `start` that arrives while `busy` is high is ignored.
- R11: `busy` rises on the cycle after `start` is accepted. It lasts 5 + W + Nodd cycles, where W is the number of wait cycles before acknowledge and Nodd is the number of odd fetch addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one step and capture the inputs below |
| offs | input | 8 | [7:4] first-pointer offset, [3:0] second-pointer offset, both signed |
| op_x_in | input | 16 | First operand |
| op_y_in | input | 16 | Second operand |
| ptr_x_in | input | 20 | First pointer |
| ptr_y_in | input | 20 | Second pointer |
| ptr_z_in | input | 20 | Third pointer |
| mask_x | input | 16 | First buffer mask (0 means 0xFFFF) |
| mask_y | input | 16 | Second buffer mask (0 means 0xFFFF) |
| busy | output | 1 | Step in progress |
| op_x | output | 16 | First operand register |
| op_y | output | 16 | Second operand register |
| ptr_x | output | 20 | First pointer register |
| ptr_y | output | 20 | Second pointer register |
| ptr_z | output | 20 | Third pointer register |
| acc_req | output | 1 | Accumulate request |
| acc_ack | input | 1 | Accumulate acknowledge |
| acc_data | output | 32 | Product to accumulate |
| acc_pov | output | 1 | Product overflow flag |
| mem_rd | output | 1 | Read strobe |
| mem_word | output | 1 | 1 selects a word read, 0 selects a byte read |
| mem_addr | output | 20 | Read address |
| mem_rdata | input | 16 | Read data, valid one cycle after the strobe |

## Verification
The assertions assume the following about the inputs:

- `acc_ack` is only raised while `acc_req` is high;
- the memory returns data exactly one cycle after each strobe;
- the masks are a power of two minus one, so each pointer stays inside its buffer.

The bench acknowledges only a pending request, after a programmable latency. Its memory model answers every strobe on the next edge with a value computed from the address. All masks it applies are contiguous low-order masks or zero.

// File: rtl/mac_fetch_seq.sv
module mac_fetch_seq #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int OW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2*OW-1:0] offs,
  input  logic [DW-1:0]   op_x_in,
  input  logic [DW-1:0]   op_y_in,
  input  logic [AW-1:0]   ptr_x_in,
  input  logic [AW-1:0]   ptr_y_in,
  input  logic [AW-1:0]   ptr_z_in,
  input  logic [DW-1:0]   mask_x,
  input  logic [DW-1:0]   mask_y,
  output logic            busy,
  output logic [DW-1:0]   op_x,
  output logic [DW-1:0]   op_y,
  output logic [AW-1:0]   ptr_x,
  output logic [AW-1:0]   ptr_y,
  output logic [AW-1:0]   ptr_z,
  output logic            acc_req,
  input  logic            acc_ack,
  output logic [2*DW-1:0] acc_data,
  output logic            acc_pov,
  output logic            mem_rd,
  output logic            mem_word,
  output logic [AW-1:0]   mem_addr,
  input  logic [DW-1:0]   mem_rdata
);
  localparam int PW = 2 * DW;
  localparam int BW = DW / 2;
  localparam logic [PW-1:0] POV_VAL = {1'b1, {(PW-1){1'b0}}};

  typedef enum logic [2:0] {
    S_IDLE, S_MUL, S_ACC, S_RDX, S_XB2, S_LDX, S_YB2, S_LDY
  } st_t;

  st_t             state;
  logic [DW-1:0]   msk_x, msk_y;
  logic [OW-1:0]   off_x, off_y;
  logic [PW-1:0]   prod;
  logic            pov;
  logic [AW-1:0]   ea;
  logic [BW-1:0]   hi;
  logic            odd;

  function automatic logic [AW-1:0] wrap_step(input logic [AW-1:0] p,
                                               input logic [DW-1:0] m,
                                               input logic [OW-1:0] o);
    logic [AW-1:0] mm, sum;
    mm  = {{(AW-DW){1'b0}}, (m == '0) ? {DW{1'b1}} : m};
    sum = p + {{(AW-OW){o[OW-1]}}, o};
    return (p & ~mm) | (sum & mm);
  endfunction

  logic [AW-1:0] nx, ny;
  assign nx = wrap_step(ptr_x, msk_x, off_x);
  assign ny = wrap_step(ptr_y, msk_y, off_y);

  logic signed [PW-1:0] full;
  logic [PW-1:0]        prod_n;
  assign full   = $signed({{DW{op_x[DW-1]}}, op_x}) * $signed({{DW{op_y[DW-1]}}, op_y});
  assign prod_n = {full[PW-2:0], 1'b0};

  logic [DW-1:0] rd_val;
  assign rd_val = odd ? {hi, mem_rdata[BW-1:0]} : mem_rdata;

  assign busy     = (state != S_IDLE);
  assign acc_req  = (state == S_ACC);
  assign acc_data = prod;
  assign acc_pov  = pov;
  assign mem_rd   = (state == S_RDX) || (state == S_XB2) ||
                    (state == S_LDX) || (state == S_YB2);
  assign mem_addr = (state == S_LDX) ? ny : ea;
  assign mem_word = (state == S_RDX) ? ~ea[0] :
                    (state == S_LDX) ? ~ny[0] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_x  <= '0;
      op_y  <= '0;
      ptr_x <= '0;
      ptr_y <= '0;
      ptr_z <= '0;
      msk_x <= '0;
      msk_y <= '0;
      off_x <= '0;
      off_y <= '0;
      prod  <= '0;
      pov   <= 1'b0;
      ea    <= '0;
      hi    <= '0;
      odd   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          op_x  <= op_x_in;
          op_y  <= op_y_in;
          ptr_x <= ptr_x_in;
          ptr_y <= ptr_y_in;
          ptr_z <= ptr_z_in;
          msk_x <= mask_x;
          msk_y <= mask_y;
          off_x <= offs[2*OW-1:OW];
          off_y <= offs[OW-1:0];
          state <= S_MUL;
        end
        S_MUL: begin
          prod  <= prod_n;
          pov   <= (prod_n == POV_VAL);
          state <= S_ACC;
        end
        S_ACC: if (acc_ack) begin
          ptr_x <= nx;
          ea    <= nx;
          state <= S_RDX;
        end
        S_RDX: begin
          ptr_z[DW-1:0] <= op_x;
          odd <= ea[0];
          if (ea[0]) begin
            ea    <= ea + AW'(1);
            state <= S_XB2;
          end else begin
            state <= S_LDX;
          end
        end
        S_XB2: begin
          hi    <= mem_rdata[BW-1:0];
          state <= S_LDX;
        end
        S_LDX: begin
          op_x  <= rd_val;
          ptr_y <= ny;
          odd   <= ny[0];
          ea    <= ny[0] ? ny + AW'(1) : ny;
          state <= ny[0] ? S_YB2 : S_LDY;
        end
        S_YB2: begin
          hi    <= mem_rdata[BW-1:0];
          state <= S_LDY;
        end
        S_LDY: begin
          op_y  <= rd_val;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_ack) |=> (acc_req && $stable(acc_data)));

  // R4
  no_read_in_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> !mem_rd);

  // R3
  pov_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> (acc_pov == (acc_data == POV_VAL)));

  // R8
  word_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_word) |-> !mem_addr[0]);

  // R8
  byte_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_word && (state == S_RDX || state == S_LDX)) |=>
      (mem_rd && !mem_word && mem_addr == $past(mem_addr) + AW'(1)));

endmodule

// File: tb/mac_fetch_seq_test.sv
module mac_fetch_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  offs = '0;
  logic [15:0] op_x_in = '0, op_y_in = '0, mask_x = '0, mask_y = '0;
  logic [19:0] ptr_x_in = '0, ptr_y_in = '0, ptr_z_in = '0;
  logic        busy, acc_req, acc_ack, acc_pov, mem_rd, mem_word;
  logic [15:0] op_x, op_y;
  logic [19:0] ptr_x, ptr_y, ptr_z, mem_addr;
  logic [31:0] acc_data;
  logic [15:0] mem_rdata = '0;

  int total = 0;
  int bad = 0;
  int ack_lat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_fetch_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .offs(offs),
    .op_x_in(op_x_in), .op_y_in(op_y_in), .ptr_x_in(ptr_x_in),
    .ptr_y_in(ptr_y_in), .ptr_z_in(ptr_z_in), .mask_x(mask_x), .mask_y(mask_y),
    .busy(busy), .op_x(op_x), .op_y(op_y), .ptr_x(ptr_x), .ptr_y(ptr_y),
    .ptr_z(ptr_z), .acc_req(acc_req), .acc_ack(acc_ack), .acc_data(acc_data),
    .acc_pov(acc_pov), .mem_rd(mem_rd), .mem_word(mem_word),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] bval(input logic [19:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ {a[19:16], 4'h9};
  endfunction

  int          cyc = 0;
  int          wcnt = 0;
  int          nrd = 0;
  int          reqn = 0;
  int          ack_cyc = 0;
  logic [31:0] got_data = '0;
  logic        got_pov = 1'b0;
  logic [20:0] rd_log [64];
  int          rd_cyc [64];

  assign acc_ack = acc_req && (wcnt == ack_lat);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (acc_req && !acc_ack) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (acc_req) reqn <= reqn + 1;
    if (acc_req && acc_ack) begin
      got_data <= acc_data;
      got_pov  <= acc_pov;
      ack_cyc  <= cyc;
    end
    if (mem_rd) begin
      mem_rdata <= mem_word ? {bval(mem_addr), bval(mem_addr + 20'd1)}
                            : {8'hEE, bval(mem_addr)};
      rd_log[nrd % 64] <= {mem_word, mem_addr};
      rd_cyc[nrd % 64] <= cyc;
      nrd <= nrd + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  function automatic logic [19:0] wrap_ref(input logic [19:0] p,
                                           input logic [15:0] m,
                                           input logic [3:0] o);
    logic [19:0] lim, moved;
    lim   = (m == 16'h0) ? 20'h0FFFF : {4'h0, m};
    moved = p + {{16{o[3]}}, o};
    return (p & ~lim) | (moved & lim);
  endfunction

  // Runs one step; glitch_at > 0 pulses start again at that busy cycle
  task automatic run_step(input string tag, input logic [15:0] a, input logic [15:0] b,
                          input logic [19:0] px, input logic [19:0] py,
                          input logic [19:0] pz, input logic [15:0] mx,
                          input logic [15:0] my, input logic [7:0] of,
                          input int lat, input int glitch_at);
    logic signed [31:0] sp;
    logic [31:0] eprod;
    logic [19:0] enx, eny;
    logic [20:0] exp_rd [4];
    int ne, n, base_rd, base_req;
    sp    = $signed({{16{a[15]}}, a}) * $signed({{16{b[15]}}, b});
    eprod = {sp[30:0], 1'b0};
    enx   = wrap_ref(px, mx, of[7:4]);
    eny   = wrap_ref(py, my, of[3:0]);
    ne = 0;
    if (enx[0]) begin
      exp_rd[ne] = {1'b0, enx}; ne++;
      exp_rd[ne] = {1'b0, enx + 20'd1}; ne++;
    end else begin
      exp_rd[ne] = {1'b1, enx}; ne++;
    end
    if (eny[0]) begin
      exp_rd[ne] = {1'b0, eny}; ne++;
      exp_rd[ne] = {1'b0, eny + 20'd1}; ne++;
    end else begin
      exp_rd[ne] = {1'b1, eny}; ne++;
    end

    @(negedge clk);
    op_x_in = a; op_y_in = b; ptr_x_in = px; ptr_y_in = py; ptr_z_in = pz;
    mask_x = mx; mask_y = my; offs = of; ack_lat = lat;
    base_rd = nrd; base_req = reqn;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      if (glitch_at > 0 && n == glitch_at) begin
        start = 1'b1;
        op_x_in = ~a; op_y_in = 16'h8000; ptr_x_in = px ^ 20'h00F0;
        ptr_y_in = py ^ 20'h0F00; ptr_z_in = ~pz; offs = ~of;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    $display("step %s: %0d busy cycles", tag, n);
    // R11
    chk("R11", "busy length", 64'(n), 64'(5 + lat + (enx[0] ? 1 : 0) + (eny[0] ? 1 : 0)));
    // R2
    chk("R2", "product", 64'(got_data), 64'(eprod));
    // R3
    chk("R3", "pov", 64'(got_pov), 64'(eprod == 32'h80000000));
    // R4
    chk("R4", "request cycles", 64'(reqn - base_req), 64'(lat + 1));
    chk("R4", "first read after ack", 64'(rd_cyc[base_rd % 64] > ack_cyc), 64'd1);
    // R5
    chk("R5", "ptr_x", 64'(ptr_x), 64'(enx));
    // R6
    chk("R6", "ptr_y", 64'(ptr_y), 64'(eny));
    // R7
    chk("R7", "ptr_z", 64'(ptr_z), 64'({pz[19:16], a}));
    // R8
    chk("R8", "read count", 64'(nrd - base_rd), 64'(ne));
    for (int i = 0; i < ne; i++)
      chk("R8", "read entry", 64'(rd_log[(base_rd + i) % 64]), 64'(exp_rd[i]));
    // R9
    chk("R9", "op_x", 64'(op_x), 64'({bval(enx), bval(enx + 20'd1)}));
    chk("R9", "op_y", 64'(op_y), 64'({bval(eny), bval(eny + 20'd1)}));
    if (glitch_at > 0) begin
      @(negedge clk);
      // R10
      chk("R10", "no restart after ignored start", 64'(busy), 64'd0);
    end
  endtask

  task automatic t_reset();
    // R1
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "acc_req", 64'(acc_req), 64'd0);
    chk("R1", "mem_rd", 64'(mem_rd), 64'd0);
    chk("R1", "regs", 64'({op_x, op_y, ptr_x} | {ptr_y, ptr_z}), 64'd0);
  endtask

  task automatic t_basic();
    run_step("even", 16'h4000, 16'h2000, 20'h00100, 20'h00200, 20'hA0000,
             16'h0000, 16'h0000, 8'h2E, 0, 0);
  endtask

  task automatic t_pov_odd();
    run_step("pov_odd", 16'h8000, 16'h8000, 20'h00101, 20'h00305, 20'h5FFFF,
             16'h0000, 16'h0000, 8'h20, 2, 0);
  endtask

  task automatic t_wrap();
    run_step("modulo", 16'hFFFD, 16'h7FFF, 20'h1234E, 20'hABCD0, 20'h31234,
             16'h000F, 16'h0007, 8'h3F, 1, 0);
  endtask

  task automatic t_mask_zero();
    run_step("mask0", 16'h8000, 16'h7FFF, 20'h3FFFF, 20'h50000, 20'h00000,
             16'h0000, 16'h0000, 8'h1F, 0, 0);
  endtask

  task automatic t_busy_start();
    run_step("restart", 16'h8001, 16'h8000, 20'h00444, 20'h00888, 20'h71111,
             16'h00FF, 16'h003F, 8'h71, 3, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL R11 watchdog got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_pov_odd();
    t_wrap();
    t_mask_zero();
    t_busy_start();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule